// File: doc/BRIEF.md
# Bus Wait-State and Arbitration Controller

This block sits on the system side of a 16-bit asynchronous CPU bus. It watches the address strobe, the function code and the address of each main-CPU cycle. It terminates the cycle with a data acknowledge, or with a peripheral-valid strobe when the cycle is an interrupt acknowledge. The acknowledge is postponed when a DRAM refresh is due, when the access falls in the sound processor's memory window, or when the video data port is not ready. The port is not ready for a write while its FIFO is full, and not ready for a read until its prefetch is done.

The same block takes the main bus away from the CPU for two other masters. The first is a video DMA, which a data-port write starts with a one-cycle `dma_start` pulse. The second is the sound processor, when it reaches into the main address space from the upper part of its own map. Bus request goes out at the first clock edge after the trigger. Ownership is taken with bus-grant-acknowledge once the CPU has granted the bus and has no strobe active. DMA wins when both masters are waiting. A free-running divider produces the CPU clock enable.

All timing is counted in master-clock cycles. "Latency" means the number of rising edges from the first edge that samples `as_n` low up to and including the edge that drives the strobe low. A latency of 1 is a zero-wait cycle.

Top module: `bus_wait_arb`

## Requirements
- R1: `cpu_ce` is high for exactly one master cycle in every CLK_DIV (default 7) master cycles.
- R2: With no refresh pending, a cycle to ROM (byte address bits 23:22 = 00), to work RAM (bits 23:16 = 0xFF) or to any unlisted address gets `dtack_n` low with latency 1, and `vpa_n` stays high.
- R3: A refresh becomes pending every REFRESH_PERIOD (default 64) master cycles after reset. The next ROM or RAM cycle takes REFRESH_LEN (default 3) extra cycles, which gives latency 1+REFRESH_LEN. That cycle clears the pending refresh, so an immediately following ROM/RAM cycle has latency 1.
- R4: A cycle to the sound window (byte address bits 23:16 = 0xA0) has latency 1+SND_WAIT (default 2).
- R5: A write to the video data port (byte address 0xC00000) holds `dtack_n` high while `vid_fifo_full` is high. The acknowledge follows one edge after the flag is seen low.
- R6: A read of the video data port holds `dtack_n` high until `vid_prefetch_rdy` is seen high, and acknowledges one edge later.
- R7: A cycle with function code 111 (interrupt acknowledge) gets `vpa_n` low with latency 1 and never `dtack_n`. `vpa_n` is never driven low for any other function code.
- R8: Once `as_n` has been high for one edge, `dtack_n` and `vpa_n` are both high at the next edge.
- R9: `br_n` goes low at the first edge that samples `dma_start` high while the arbiter is idle.
- R10: When `bg_n` is low and `as_n` is high, a requesting arbiter drives `bgack_n` low and releases `br_n` at the same edge. For DMA, `dma_grant` stays high until `dma_done` is sampled, which also releases `bgack_n`.
- R11: A sound request with `snd_addr` at or above 0x7F00 is acknowledged only after a full request/grant/acknowledge sequence. `snd_ack` pulses at the edge that releases `bgack_n`. A request below 0x7F00 is acknowledged at the next edge without `br_n`.
- R12: When a DMA trigger and a far sound request are seen at the same edge, the DMA owns the bus first. `snd_ack` stays low until the DMA has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | output | 1 | CPU clock enable, one pulse per CLK_DIV cycles |
| as_n | input | 1 | CPU address strobe, active low |
| rw | input | 1 | CPU direction, 1 = read |
| addr | input | 23 | CPU word address, byte address bits 23:1 |
| fc | input | 3 | CPU function code |
| dtack_n | output | 1 | Data acknowledge, active low |
| vpa_n | output | 1 | Peripheral-valid (autovector) strobe, active low |
| br_n | output | 1 | Bus request to CPU, active low |
| bg_n | input | 1 | Bus grant from CPU, active low |
| bgack_n | output | 1 | Bus grant acknowledge, active low |
| vid_fifo_full | input | 1 | Video write FIFO full |
| vid_prefetch_rdy | input | 1 | Video read prefetch complete |
| dma_start | input | 1 | One-cycle pulse: a port write has started DMA |
| dma_done | input | 1 | DMA transfer finished |
| dma_grant | output | 1 | DMA engine owns the main bus |
| snd_req | input | 1 | Sound CPU access request, held until acknowledged |
| snd_addr | input | 16 | Sound CPU address |
| snd_ack | output | 1 | One-cycle acknowledge of the sound access |

## Verification
The assertions assume that the CPU keeps `fc`, `rw` and `addr` stable while `as_n` is low, and that the sound processor keeps `snd_addr` stable while `snd_req` is high. They also assume that `dma_start` is a single-cycle pulse and that `bg_n` is driven low only in answer to `br_n`. The stimulus drives every input at the falling clock edge and changes the cycle attributes only while the strobe is high. It raises `snd_req` and sets its address together, and drops both together with the acknowledge. A small model of the CPU in the bench copies `br_n` onto `bg_n` one half-cycle later, so a grant always follows a request.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  localparam int AW = 23;               // word address, byte bits 23:1
  localparam logic [2:0] FC_IACK = 3'b111;

  typedef enum logic [2:0] {
    RG_ROM,
    RG_RAM,
    RG_SND,
    RG_VID,
    RG_MISC
  } region_t;

  // word-address decode of the main map
  function automatic region_t map_decode(input logic [AW-1:0] wa);
    region_t r;
    if (wa[22:21] == 2'b00)            r = RG_ROM;
    else if (wa[22:15] == 8'hFF)       r = RG_RAM;
    else if (wa[22:15] == 8'hA0)       r = RG_SND;
    else if (wa == 23'h600000)         r = RG_VID;
    else                               r = RG_MISC;
    return r;
  endfunction

endpackage

// File: rtl/sbc_clkdiv.sv
module sbc_clkdiv #(
  parameter int CLK_DIV = 7
) (
  input  logic clk,
  input  logic rst,
  output logic ce
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ce  <= 1'b0;
    end else begin
      if (cnt == DW'(CLK_DIV - 1)) cnt <= '0;
      else                         cnt <= cnt + 1'b1;
      ce <= (cnt == DW'(CLK_DIV - 1));
    end
  end

  generate
    if (CLK_DIV > 1) begin : g_chk
      // R1
      ce_single_chk: assert property (@(posedge clk) disable iff (rst)
        ce |=> !ce);
    end
  endgenerate

endmodule

// File: rtl/sbc_refresh.sv
module sbc_refresh #(
  parameter int REFRESH_PERIOD = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic pend
);
  localparam int PW = $clog2(REFRESH_PERIOD);

  logic [PW-1:0] tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick <= '0;
      pend <= 1'b0;
    end else begin
      if (tick == PW'(REFRESH_PERIOD - 1)) begin
        tick <= '0;
        pend <= 1'b1;
      end else begin
        tick <= tick + 1'b1;
        if (take) pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sbc_cycle.sv
module sbc_cycle
  import sbc_pkg::*;
#(
  parameter int REFRESH_LEN = 3,
  parameter int SND_WAIT    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          as_n,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    fc,
  input  logic          bus_held,
  input  logic          fifo_full,
  input  logic          prefetch_rdy,
  input  logic          refresh_pend,
  output logic          refresh_take,
  output logic          dtack_n,
  output logic          vpa_n
);
  localparam int MAXW = (REFRESH_LEN > SND_WAIT) ? REFRESH_LEN : SND_WAIT;
  localparam int CW   = $clog2(MAXW + 2);

  typedef enum logic [2:0] {C_IDLE, C_WAIT, C_VWR, C_VRD, C_HOLD} cstate_t;

  cstate_t       state;
  logic [CW-1:0] wcnt;
  region_t       rg;
  logic          start;
  logic          is_mem;

  assign rg           = map_decode(addr);
  assign start        = (state == C_IDLE) && !as_n && !bus_held;
  assign is_mem       = (rg == RG_ROM) || (rg == RG_RAM);
  assign refresh_take = start && (fc != FC_IACK) && is_mem && refresh_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= C_IDLE;
      wcnt    <= '0;
      dtack_n <= 1'b1;
      vpa_n   <= 1'b1;
    end else begin
      case (state)
        C_IDLE: begin
          if (start) begin
            if (fc == FC_IACK) begin
              vpa_n <= 1'b0;
              state <= C_HOLD;
            end else begin
              unique case (rg)
                RG_ROM, RG_RAM: begin
                  if (refresh_pend && (REFRESH_LEN > 0)) begin
                    wcnt  <= CW'(REFRESH_LEN - 1);
                    state <= C_WAIT;
                  end else begin
                    dtack_n <= 1'b0;
                    state   <= C_HOLD;
                  end
                end
                RG_SND: begin
                  if (SND_WAIT > 0) begin
                    wcnt  <= CW'(SND_WAIT - 1);
                    state <= C_WAIT;
                  end else begin
                    dtack_n <= 1'b0;
                    state   <= C_HOLD;
                  end
                end
                RG_VID: begin
                  if (rw) begin
                    if (prefetch_rdy) begin
                      dtack_n <= 1'b0;
                      state   <= C_HOLD;
                    end else begin
                      state <= C_VRD;
                    end
                  end else begin
                    if (!fifo_full) begin
                      dtack_n <= 1'b0;
                      state   <= C_HOLD;
                    end else begin
                      state <= C_VWR;
                    end
                  end
                end
                default: begin
                  dtack_n <= 1'b0;
                  state   <= C_HOLD;
                end
              endcase
            end
          end
        end
        C_WAIT: begin
          if (as_n) begin
            state <= C_IDLE;
          end else if (wcnt == '0) begin
            dtack_n <= 1'b0;
            state   <= C_HOLD;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        C_VWR: begin
          if (as_n) begin
            state <= C_IDLE;
          end else if (!fifo_full) begin
            dtack_n <= 1'b0;
            state   <= C_HOLD;
          end
        end
        C_VRD: begin
          if (as_n) begin
            state <= C_IDLE;
          end else if (prefetch_rdy) begin
            dtack_n <= 1'b0;
            state   <= C_HOLD;
          end
        end
        C_HOLD: begin
          if (as_n) begin
            dtack_n <= 1'b1;
            vpa_n   <= 1'b1;
            state   <= C_IDLE;
          end
        end
        default: state <= C_IDLE;
      endcase
    end
  end

  // R7
  vpa_dtack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !vpa_n |-> dtack_n);

  // R7
  vpa_only_iack_chk: assert property (@(posedge clk) disable iff (rst)
    (!vpa_n && !as_n) |-> (fc == FC_IACK));

  // R7
  dtack_not_iack_chk: assert property (@(posedge clk) disable iff (rst)
    (!dtack_n && !as_n) |-> (fc != FC_IACK));

  // R8
  strobe_release_chk: assert property (@(posedge clk) disable iff (rst)
    (as_n && $past(as_n)) |-> (dtack_n && vpa_n));

  // R5
  vid_wr_full_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(dtack_n) && !rw && (rg == RG_VID)) |-> !$past(fifo_full));

endmodule

// File: rtl/sbc_arbiter.sv
module sbc_arbiter #(
  parameter int          SND_AW       = 16,
  parameter logic [15:0] SND_FAR_BASE = 16'h7F00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              as_n,
  input  logic              bg_n,
  input  logic              dma_start,
  input  logic              dma_done,
  input  logic              snd_req,
  input  logic [SND_AW-1:0] snd_addr,
  output logic              br_n,
  output logic              bgack_n,
  output logic              dma_grant,
  output logic              snd_ack
);
  typedef enum logic [1:0] {AR_IDLE, AR_REQ, AR_OWN} astate_t;

  astate_t state;
  logic    own_dma;
  logic    dma_pend;
  logic    snd_far;

  assign snd_far = (snd_addr >= SND_AW'(SND_FAR_BASE));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= AR_IDLE;
      own_dma   <= 1'b0;
      dma_pend  <= 1'b0;
      br_n      <= 1'b1;
      bgack_n   <= 1'b1;
      dma_grant <= 1'b0;
      snd_ack   <= 1'b0;
    end else begin
      snd_ack <= 1'b0;
      if (dma_start && (state != AR_IDLE)) dma_pend <= 1'b1;
      case (state)
        AR_IDLE: begin
          if (dma_start || dma_pend) begin
            dma_pend <= 1'b0;
            own_dma  <= 1'b1;
            br_n     <= 1'b0;
            state    <= AR_REQ;
          end else if (snd_req && snd_far && !snd_ack) begin
            own_dma <= 1'b0;
            br_n    <= 1'b0;
            state   <= AR_REQ;
          end else if (snd_req && !snd_far && !snd_ack) begin
            snd_ack <= 1'b1;
          end
        end
        AR_REQ: begin
          if (!bg_n && as_n) begin
            bgack_n   <= 1'b0;
            br_n      <= 1'b1;
            dma_grant <= own_dma;
            state     <= AR_OWN;
          end
        end
        AR_OWN: begin
          if (own_dma) begin
            if (dma_done) begin
              bgack_n   <= 1'b1;
              dma_grant <= 1'b0;
              state     <= AR_IDLE;
            end
          end else begin
            snd_ack <= 1'b1;
            bgack_n <= 1'b1;
            state   <= AR_IDLE;
          end
        end
        default: state <= AR_IDLE;
      endcase
    end
  end

  // R9
  dma_br_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(dma_start) && $past(state == AR_IDLE)) |-> !br_n);

  // R10
  br_release_chk: assert property (@(posedge clk) disable iff (rst)
    !bgack_n |-> br_n);

  // R10
  grant_seen_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bgack_n) |-> ($past(!bg_n) && $past(as_n)));

  // R12
  owner_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(dma_grant && snd_ack));

  // R11
  snd_far_owned_chk: assert property (@(posedge clk) disable iff (rst)
    (snd_ack && snd_far) |-> $past(!bgack_n));

endmodule

// File: rtl/bus_wait_arb.sv
module bus_wait_arb
  import sbc_pkg::*;
#(
  parameter int CLK_DIV        = 7,
  parameter int REFRESH_PERIOD = 64,
  parameter int REFRESH_LEN    = 3,
  parameter int SND_WAIT       = 2,
  parameter int SND_AW         = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cpu_ce,
  input  logic              as_n,
  input  logic              rw,
  input  logic [AW-1:0]     addr,
  input  logic [2:0]        fc,
  output logic              dtack_n,
  output logic              vpa_n,
  output logic              br_n,
  input  logic              bg_n,
  output logic              bgack_n,
  input  logic              vid_fifo_full,
  input  logic              vid_prefetch_rdy,
  input  logic              dma_start,
  input  logic              dma_done,
  output logic              dma_grant,
  input  logic              snd_req,
  input  logic [SND_AW-1:0] snd_addr,
  output logic              snd_ack
);
  logic ref_pend;
  logic ref_take;

  sbc_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .ce  (cpu_ce)
  );

  sbc_refresh #(.REFRESH_PERIOD(REFRESH_PERIOD)) u_ref (
    .clk  (clk),
    .rst  (rst),
    .take (ref_take),
    .pend (ref_pend)
  );

  sbc_cycle #(.REFRESH_LEN(REFRESH_LEN), .SND_WAIT(SND_WAIT)) u_cyc (
    .clk          (clk),
    .rst          (rst),
    .as_n         (as_n),
    .rw           (rw),
    .addr         (addr),
    .fc           (fc),
    .bus_held     (!bgack_n),
    .fifo_full    (vid_fifo_full),
    .prefetch_rdy (vid_prefetch_rdy),
    .refresh_pend (ref_pend),
    .refresh_take (ref_take),
    .dtack_n      (dtack_n),
    .vpa_n        (vpa_n)
  );

  sbc_arbiter #(.SND_AW(SND_AW)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .as_n      (as_n),
    .bg_n      (bg_n),
    .dma_start (dma_start),
    .dma_done  (dma_done),
    .snd_req   (snd_req),
    .snd_addr  (snd_addr),
    .br_n      (br_n),
    .bgack_n   (bgack_n),
    .dma_grant (dma_grant),
    .snd_ack   (snd_ack)
  );

endmodule

// File: tb/sim_bus_wait_arb.sv
module sim_bus_wait_arb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_ce;
  logic        as_n = 1'b1;
  logic        rw = 1'b1;
  logic [22:0] addr = '0;
  logic [2:0]  fc = 3'b101;
  logic        dtack_n, vpa_n, br_n, bgack_n, dma_grant, snd_ack;
  logic        bg_n = 1'b1;
  logic        vid_fifo_full = 1'b0;
  logic        vid_prefetch_rdy = 1'b1;
  logic        dma_start = 1'b0;
  logic        dma_done = 1'b0;
  logic        snd_req = 1'b0;
  logic [15:0] snd_addr = '0;

  int pass_cnt = 0;
  int fail_cnt = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // simple CPU grant model
  always @(negedge clk) bg_n <= br_n;

  bus_wait_arb u0 (
    .clk(clk), .rst(rst), .cpu_ce(cpu_ce),
    .as_n(as_n), .rw(rw), .addr(addr), .fc(fc),
    .dtack_n(dtack_n), .vpa_n(vpa_n),
    .br_n(br_n), .bg_n(bg_n), .bgack_n(bgack_n),
    .vid_fifo_full(vid_fifo_full), .vid_prefetch_rdy(vid_prefetch_rdy),
    .dma_start(dma_start), .dma_done(dma_done), .dma_grant(dma_grant),
    .snd_req(snd_req), .snd_addr(snd_addr), .snd_ack(snd_ack)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    if (ok) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_access(input logic [23:0] baddr, input logic rd, input logic [2:0] f,
                            output int lat, output bit got_vpa, output bit got_dtack);
    @(negedge clk);
    addr = baddr[23:1]; rw = rd; fc = f; as_n = 1'b0;
    lat = 0;
    while (lat < 40) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (!dtack_n || !vpa_n) break;
    end
    got_vpa = !vpa_n;
    got_dtack = !dtack_n;
    as_n = 1'b1;
    @(negedge clk);
    check(dtack_n && vpa_n, "R8 release", {30'd0, dtack_n, vpa_n}, 3);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(dtack_n && vpa_n && br_n && bgack_n && !dma_grant && !snd_ack,
          "reset state", {26'd0, dtack_n, vpa_n, br_n, bgack_n, dma_grant, snd_ack}, 60);
  endtask

  task automatic t_zero_wait;
    int lat; bit v, d;
    bus_access(24'h001000, 1'b1, 3'b110, lat, v, d);
    check(lat == 1 && d && !v, "R2 ROM", lat, 1);
    bus_access(24'hFF0100, 1'b0, 3'b101, lat, v, d);
    check(lat == 1 && d && !v, "R2 RAM", lat, 1);
    bus_access(24'h400000, 1'b1, 3'b101, lat, v, d);
    check(lat == 1 && d && !v, "R2 misc", lat, 1);
  endtask

  task automatic t_iack;
    int lat; bit v, d;
    bus_access(24'hFFFFF8, 1'b1, 3'b111, lat, v, d);
    check(lat == 1 && v && !d, "R7 iack", lat, 1);
  endtask

  task automatic t_refresh;
    int lat; bit v, d;
    while (cyc < 140 || (cyc % 64) != 8) @(negedge clk);
    bus_access(24'hFF2000, 1'b1, 3'b101, lat, v, d);
    check(lat == 4 && d, "R3 refresh stall", lat, 4);
    bus_access(24'h002000, 1'b1, 3'b110, lat, v, d);
    check(lat == 1 && d, "R3 refresh consumed", lat, 1);
  endtask

  task automatic t_sound_window;
    int lat; bit v, d;
    bus_access(24'hA01234, 1'b1, 3'b101, lat, v, d);
    check(lat == 3 && d, "R4 sound window", lat, 3);
  endtask

  task automatic t_video;
    int lat; bit v, d;
    bus_access(24'hC00000, 1'b0, 3'b101, lat, v, d);
    check(lat == 1 && d, "R5 write not full", lat, 1);
    vid_fifo_full = 1'b1;
    fork
      bus_access(24'hC00000, 1'b0, 3'b101, lat, v, d);
      begin
        @(negedge clk);
        repeat (3) @(posedge clk);
        @(negedge clk);
        vid_fifo_full = 1'b0;
      end
    join
    check(lat == 4 && d, "R5 write held while full", lat, 4);
    vid_prefetch_rdy = 1'b0;
    fork
      bus_access(24'hC00000, 1'b1, 3'b101, lat, v, d);
      begin
        @(negedge clk);
        repeat (2) @(posedge clk);
        @(negedge clk);
        vid_prefetch_rdy = 1'b1;
      end
    join
    check(lat == 3 && d, "R6 read waits prefetch", lat, 3);
  endtask

  task automatic t_dma;
    @(negedge clk);
    dma_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dma_start = 1'b0;
    check(br_n == 1'b0, "R9 br on dma start", br_n, 0);
    @(posedge clk);
    @(negedge clk);
    check(!bgack_n && br_n && dma_grant, "R10 grant taken",
          {29'd0, bgack_n, br_n, dma_grant}, 3'b011);
    repeat (4) @(negedge clk);
    check(dma_grant && !bgack_n, "R10 grant held", dma_grant, 1);
    dma_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dma_done = 1'b0;
    check(bgack_n && !dma_grant, "R10 release on done", {30'd0, bgack_n, dma_grant}, 2);
    @(negedge clk);
  endtask

  task automatic t_sound_req(input logic [15:0] sa, input bit far);
    bit saw_br = 0, saw_bgack = 0, got = 0;
    @(negedge clk);
    snd_addr = sa; snd_req = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (!br_n) saw_br = 1;
      if (!bgack_n) saw_bgack = 1;
      if (snd_ack) begin got = 1; break; end
    end
    snd_req = 1'b0;
    if (far)
      check(got && saw_br && saw_bgack, "R11 far access arbitrated",
            {29'd0, got, saw_br, saw_bgack}, 7);
    else
      check(got && !saw_br && !saw_bgack, "R11 local access direct",
            {29'd0, got, saw_br, saw_bgack}, 4);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_priority;
    bit got = 0, early = 0;
    @(negedge clk);
    dma_start = 1'b1;
    snd_addr = 16'h8000; snd_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dma_start = 1'b0;
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
      if (snd_ack) early = 1;
    end
    check(dma_grant && !early, "R12 dma first", {30'd0, dma_grant, early}, 2);
    dma_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dma_done = 1'b0;
    if (snd_ack) early = 1;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (snd_ack) begin got = 1; break; end
    end
    snd_req = 1'b0;
    check(got && !early, "R12 sound served after dma", {30'd0, got, early}, 2);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_clock_enable;
    int n = 0;
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      if (cpu_ce) n++;
    end
    check(n == 10, "R1 clock enable rate", n, 10);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_zero_wait;
    t_iack;
    t_sound_window;
    t_video;
    t_clock_enable;
    t_refresh;
    t_dma;
    t_sound_req(16'h7F00, 1'b1);
    t_sound_req(16'h7EFF, 1'b0);
    t_priority;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fail_cnt++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    finish_run;
  end

endmodule